// File: doc/BRIEF.md
# UART Interrupt Priority and Identification Unit

This unit sits next to a UART core and merges its five interrupt causes into one interrupt line and one status byte for software. The causes are receiver line status, receive data available, receive time-out, transmitter holding register empty and modem status. Each cause has its own enable. An enabled cause that fires sets a pending flag, and that flag holds until software acknowledges it.

The status byte is registered. Its low nibble gives the most urgent pending cause, or an idle code when nothing is pending. Its upper bits report the FIFO configuration. A read strobe from the bus decoder acknowledges only the cause shown in the byte at the moment of the read. Further pending causes therefore come out one per read, from most to least urgent.

Top module: `uart_irq_ident`

## Requirements
- R1: The urgency order is: line status (source bit 0), then receive time-out (bit 2), then receive data available (bit 1), then holding empty (bit 3), then modem status (bit 4). Only the most urgent enabled pending cause is reported.
- R2: Status bits [3:0] are 4'b0110 for line status, 4'b1100 for receive time-out, 4'b0100 for receive data available, 4'b0010 for holding empty and 4'b0000 for modem status.
- R3: Status bit 0 is 1 when no enabled cause is pending. Synchronous reset clears every pending flag, sets the status byte to 8'h01 and drives `irq_o` low.
- R4: An event on `src_evt[i]` while `src_en[i]` is high sets pending flag i. The status byte shows the flag after the next rising edge.
- R5: A read strobe clears only the cause the status byte reports during that cycle. Every other pending cause stays pending and is reported on later reads.
- R6: The status byte sampled during a read cycle is the value before that read's clear. The clear shows in the byte one cycle later.
- R7: An event on the reported cause in the same cycle as its read leaves that cause pending.
- R8: While its enable is low, a cause never sets its flag and never appears in the status byte. A pending flag whose enable is dropped is masked from the byte and from `irq_o`.
- R9: `irq_o` is high when any enabled cause is pending. It follows the flags one cycle later.
- R10: Status bits [7:6] both equal `fifo_en`. Bit 5 equals `fifo_deep` (1 = 64-entry mode, 0 = 16-entry mode). Bit 4 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 5 | Cause events: bit0 line status, bit1 receive data, bit2 time-out, bit3 holding empty, bit4 modem |
| src_en | input | 5 | Per-cause enables, same bit order |
| fifo_en | input | 1 | FIFOs enabled, mirrored on bits [7:6] |
| fifo_deep | input | 1 | 64-entry FIFO mode, mirrored on bit 5 |
| rd_stb | input | 1 | One-cycle status-read acknowledge |
| stat_q | output | 8 | Registered status byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the unit with the package's default constants: five causes and an 8-bit status byte. At that size every mix of enables and events can be reached in a few cycles. A vector table covers the priority ordering across mixed event and enable masks. Directed runs drain all five causes one read at a time, race an event against its own read, mask causes through the enables, and step the FIFO configuration bits.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int STAT_W  = 8;
  localparam int CODE_W  = 4;

  // source bit positions
  localparam int SRC_LINE  = 0;
  localparam int SRC_RXD   = 1;
  localparam int SRC_TOUT  = 2;
  localparam int SRC_THRE  = 3;
  localparam int SRC_MODEM = 4;

  // sources from most to least urgent
  localparam int PRIO_ORDER [NUM_SRC] = '{SRC_LINE, SRC_TOUT, SRC_RXD, SRC_THRE, SRC_MODEM};

  localparam logic [CODE_W-1:0] CODE_IDLE = 4'b0001;

  function automatic logic [CODE_W-1:0] src_code(input int s);
    case (s)
      SRC_LINE:  return 4'b0110;
      SRC_RXD:   return 4'b0100;
      SRC_TOUT:  return 4'b1100;
      SRC_THRE:  return 4'b0010;
      default:   return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic en_i,
  input  logic clr_i,
  output logic pend_d,
  output logic pend_q
);
  always_comb pend_d = (pend_q & ~clr_i) | (evt_i & en_i);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_d;
  end

  // R8: a disabled source cannot raise its flag
  a_r8_no_set_when_off: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !pend_q) |=> !pend_q);
  // R7: an event wins over a clear in the same cycle
  a_r7_evt_beats_clr: assert property (@(posedge clk) disable iff (rst)
    (evt_i && en_i) |=> pend_q);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] act_i,
  output logic [NUM_SRC-1:0] win_o,
  output logic [CODE_W-1:0]  code_o
);
  always_comb begin
    win_o  = '0;
    code_o = CODE_IDLE;
    for (int k = NUM_SRC-1; k >= 0; k--) begin
      if (act_i[PRIO_ORDER[k]]) begin
        win_o  = '0;
        win_o[PRIO_ORDER[k]] = 1'b1;
        code_o = src_code(PRIO_ORDER[k]);
      end
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               fifo_en,
  input  logic               fifo_deep,
  input  logic               rd_stb,
  output logic [STAT_W-1:0]  stat_q,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] pend_d, pend_q, rep_q, win_d, clr;
  logic [CODE_W-1:0]  code_d;

  // clear only the source currently shown in the status byte
  always_comb clr = rd_stb ? rep_q : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_src_latch u_latch (
      .clk   (clk),
      .rst   (rst),
      .evt_i (src_evt[i]),
      .en_i  (src_en[i]),
      .clr_i (clr[i]),
      .pend_d(pend_d[i]),
      .pend_q(pend_q[i])
    );
  end

  irq_prio_pick u_pick (
    .act_i (pend_d & src_en),
    .win_o (win_d),
    .code_o(code_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= {{(STAT_W-1){1'b0}}, 1'b1};
      rep_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_q <= {fifo_en, fifo_en, fifo_deep, 1'b0, code_d};
      rep_q  <= win_d;
      irq_o  <= |(pend_q & src_en);
    end
  end

  // R1: at most one source is reported at a time
  a_r1_single_report: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rep_q));
  // R5: a read never removes a source other than the reported one
  a_r5_others_kept: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> (($past(pend_q) & ~$past(rep_q) & ~pend_q) == '0));
  // R3: idle bit agrees with the reported source
  a_r3_idle_bit: assert property (@(posedge clk) disable iff (rst)
    stat_q[0] == (rep_q == '0) || (rep_q[SRC_MODEM] == 1'b1 && !stat_q[0]));
  // R9: an enabled pending source raises the interrupt next cycle
  a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
    (|(pend_q & src_en)) |=> irq_o);
  // R10: bit 4 never set
  a_r10_bit4_zero: assert property (@(posedge clk) disable iff (rst)
    !stat_q[4]);
endmodule

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] src_evt = '0;
  logic [4:0] src_en = '0;
  logic       fifo_en = 1'b0;
  logic       fifo_deep = 1'b0;
  logic       rd_stb = 1'b0;
  logic [7:0] stat_q;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rst(rst), .src_evt(src_evt), .src_en(src_en),
    .fifo_en(fifo_en), .fifo_deep(fifo_deep), .rd_stb(rd_stb),
    .stat_q(stat_q), .irq_o(irq_o)
  );

  // {evt[4:0], en[4:0], expected low nibble}
  localparam logic [13:0] VEC [8] = '{
    {5'b11111, 5'b11111, 4'b0110},
    {5'b11110, 5'b11111, 4'b1100},
    {5'b11010, 5'b11111, 4'b0100},
    {5'b11000, 5'b11111, 4'b0010},
    {5'b10000, 5'b11111, 4'b0000},
    {5'b00000, 5'b11111, 4'b0001},
    {5'b11111, 5'b11100, 4'b1100},
    {5'b00011, 5'b11100, 4'b0001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; src_evt = '0; rd_stb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] e);
    src_evt = e;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic read_stat(output logic [7:0] v);
    v = stat_q;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    // R3: reset state
    @(negedge clk);
    @(negedge clk);
    chk("R3 reset stat", stat_q, 8'h01);
    chk("R3 reset irq", irq_o, 1'b0);
    rst = 1'b0;

    // R1 R2 R4 R8: table of mixed events and enables
    foreach (VEC[i]) begin
      do_reset();
      src_en = VEC[i][8:4];
      pulse(VEC[i][13:9]);
      chk("R1 R2 R4 priority code", stat_q, {4'b0000, VEC[i][3:0]});
    end

    // R5 R6: drain all five in order, pre-clear value seen on each read
    do_reset();
    src_en = 5'b11111;
    pulse(5'b11111);
    read_stat(v); chk("R6 read1 line", v, 8'h06);
    read_stat(v); chk("R5 read2 timeout", v, 8'h0C);
    read_stat(v); chk("R5 read3 rx data", v, 8'h04);
    read_stat(v); chk("R5 read4 thre", v, 8'h02);
    chk("R9 irq still high", irq_o, 1'b1);
    read_stat(v); chk("R5 read5 modem", v, 8'h00);
    chk("R3 idle after drain", stat_q, 8'h01);
    @(negedge clk);
    chk("R9 irq low after drain", irq_o, 1'b0);

    // R7: event on reported source during its read
    do_reset();
    src_en = 5'b11111;
    pulse(5'b00001);
    src_evt = 5'b00001;
    read_stat(v);
    src_evt = '0;
    chk("R7 read value", v, 8'h06);
    chk("R7 stays pending", stat_q, 8'h06);

    // R8: disabled source never latches
    do_reset();
    src_en = 5'b11110;
    pulse(5'b00001);
    @(negedge clk);
    chk("R8 disabled stat", stat_q, 8'h01);
    chk("R8 disabled irq", irq_o, 1'b0);
    src_en = 5'b11111;
    @(negedge clk);
    chk("R8 not latched later", stat_q, 8'h01);
    // R8: masking a pending source
    pulse(5'b01000);
    src_en = 5'b10111;
    @(negedge clk);
    @(negedge clk);
    chk("R8 masked stat", stat_q, 8'h01);
    chk("R8 masked irq", irq_o, 1'b0);

    // R9: irq one cycle behind the flag
    do_reset();
    src_en = 5'b11111;
    pulse(5'b01000);
    chk("R9 stat now", stat_q, 8'h02);
    chk("R9 irq not yet", irq_o, 1'b0);
    @(negedge clk);
    chk("R9 irq rises", irq_o, 1'b1);

    // R10: FIFO configuration bits
    fifo_en = 1'b1; fifo_deep = 1'b1;
    @(negedge clk);
    chk("R10 deep mode", stat_q, 8'hE2);
    fifo_deep = 1'b0;
    @(negedge clk);
    chk("R10 16 mode", stat_q, 8'hC2);
    fifo_en = 1'b0;
    @(negedge clk);
    chk("R10 fifo off", stat_q, 8'h02);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule